// File: doc/BRIEF.md
# Deterministic Transactional Commit Sequencer

This block orders the commits of speculative quanta running as memory transactions on a group of cores. A single deterministic token walks the cores in a fixed round-robin order, and a core may commit its finished quantum only while it holds the token. The order of quanta at any moment is therefore set by the token: the order position of core `c` is `(c - token) mod NCORE`. Position 0 is the token holder and is the earliest quantum; higher positions are later.

Conflict detection, versioned storage and data forwarding paths sit outside the block. They report into it per core. `conflict` flags an access that breaks the serial order. Write-after-write and write-after-read overlaps never reach it, because renamed storage absorbs them. `fwd_valid` with `fwd_src` flags that the core's quantum read uncommitted data from another core's quantum. The block answers with a per-core `commit_grant` pulse and a per-core `squash` pulse. A squashed core discards its quantum, restarts it and must report completion again. Each core has at most one quantum outstanding.

With `fwd_en` low, any forwarded read counts as an order violation. With `fwd_en` high, a read from an earlier quantum is accepted and remembered as a link. If the source quantum is later squashed, every later quantum is squashed in the same cycle.

Top module: `det_commit_seq`

## Requirements
- R1: After reset the token is at core 0, and with idle inputs neither `commit_grant` nor `squash` is asserted.
- R2: `commit_grant` has at most one bit set. It goes only to the token holder, and only in the cycle after that core signalled completion (or later). A finished core that does not hold the token gets no grant.
- R3: Each grant moves the token to the next core (0,1,...,NCORE-1,0). The token waits at a core that has not finished, and never skips it.
- R4: `conflict[c]` squashes core `c` in the same cycle. Its pending commit request is discarded, so it needs a new completion before it can be granted.
- R5: A completion recorded by a core that does not hold the token stays pending for any number of cycles until the token arrives.
- R6: With `fwd_en` low, any `fwd_valid[c]` squashes core `c` in the same cycle.
- R7: With `fwd_en` high, a forward whose source has a smaller order position than the consumer causes no squash. A forward from the same core or from a later position squashes the consumer in the same cycle. This includes any forward into the token holder.
- R8: A squash of a core that has forwarded data to an accepted consumer also squashes every core with a larger order position, in the same cycle. Cores with smaller positions are not squashed.
- R9: A forwarding link ends when its source commits or is squashed. A later squash of that core then does not spread to other cores.
- R10: `quantum_ovf[c]` ends the quantum and requests a commit exactly as `quantum_done[c]` does. Both together make a single request.
- R11: If a core is squashed in the cycle its grant would be given, the squash wins: no grant is given and the token does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fwd_en | input | 1 | 1: accept forwarding from earlier quanta; 0: every forwarded read is a violation |
| quantum_done | input | NCORE | Per-core pulse: quantum finished, requests commit |
| quantum_ovf | input | NCORE | Per-core pulse: deterministic transaction overflow ended the quantum |
| conflict | input | NCORE | Per-core pulse: order-violating access detected |
| fwd_valid | input | NCORE | Per-core pulse: quantum consumed uncommitted data |
| fwd_src | input | NCORE*IDXW | Source core of each forward; core c uses bits [c*IDXW +: IDXW] |
| commit_grant | output | NCORE | Per-core commit permission pulse |
| squash | output | NCORE | Per-core squash pulse |

## Verification
A commit grant to the token holder and a cascaded squash of later quanta can land in the same cycle. The bench provokes this by letting core 0 finish, accepting a forward from core 1 into core 2, and then flagging a conflict on core 1 in the cycle core 0's grant is due. It expects core 0 to be granted while cores 1 to 3 are squashed. A second collision puts a conflict on the token holder in the cycle its grant is due. There the squash must take priority and the token must stay put, which the following grant sequence confirms.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

  // Position of a core in the current deterministic order (0 = token holder).
  function automatic int order_pos(input int core, input int tok, input int ncore);
    return (core >= tok) ? (core - tok) : (core + ncore - tok);
  endfunction

  // True when core a comes strictly before core b in the current order.
  function automatic logic precedes(input int a, input int b, input int tok, input int ncore);
    return order_pos(a, tok, ncore) < order_pos(b, tok, ncore);
  endfunction

endpackage

// File: rtl/dcs_token_ring.sv
module dcs_token_ring #(
  parameter int NCORE = 4,
  localparam int IDXW = $clog2(NCORE)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  output logic [IDXW-1:0] tok
);
  localparam logic [IDXW-1:0] LAST = IDXW'(NCORE - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)       tok <= '0;
    else if (advance) tok <= (tok == LAST) ? '0 : tok + 1'b1;
  end
endmodule

// File: rtl/dcs_squash_net.sv
module dcs_squash_net #(
  parameter int NCORE = 4,
  localparam int IDXW = $clog2(NCORE)
) (
  input  logic [IDXW-1:0]       tok,
  input  logic                  fwd_en,
  input  logic [NCORE-1:0]      conflict,
  input  logic [NCORE-1:0]      fwd_valid,
  input  logic [NCORE*IDXW-1:0] fwd_src,
  input  logic [NCORE-1:0]      link_out,
  output logic [NCORE-1:0]      direct_sq,
  output logic [NCORE-1:0]      squash,
  output logic [NCORE-1:0]      link_set
);
  import dcs_pkg::*;

  logic [IDXW-1:0]  src_of [NCORE];
  logic [NCORE-1:0] fwd_ok;

  for (genvar g = 0; g < NCORE; g++) begin : g_src
    assign src_of[g] = fwd_src[g*IDXW +: IDXW];
  end

  // Direct causes: explicit conflict, or a forward that is not allowed.
  always_comb begin
    for (int c = 0; c < NCORE; c++) begin
      fwd_ok[c]    = fwd_valid[c] & fwd_en &
                     precedes(int'(src_of[c]), c, int'(tok), NCORE);
      direct_sq[c] = conflict[c] | (fwd_valid[c] & ~fwd_ok[c]);
    end
  end

  // Cascade: a squashed forwarding source takes every later quantum with it.
  always_comb begin
    for (int c = 0; c < NCORE; c++) begin
      squash[c] = direct_sq[c];
      for (int s = 0; s < NCORE; s++) begin
        if (direct_sq[s] && link_out[s] && precedes(s, c, int'(tok), NCORE))
          squash[c] = 1'b1;
      end
    end
  end

  // New links from accepted forwards whose consumer survives this cycle.
  always_comb begin
    link_set = '0;
    for (int c = 0; c < NCORE; c++) begin
      for (int s = 0; s < NCORE; s++) begin
        if (fwd_ok[c] && !squash[c] && src_of[c] == IDXW'(s))
          link_set[s] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dcs_quantum_track.sv
module dcs_quantum_track #(
  parameter int NCORE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCORE-1:0] finish,
  input  logic [NCORE-1:0] grant,
  input  logic [NCORE-1:0] squash,
  input  logic [NCORE-1:0] link_set,
  output logic [NCORE-1:0] pend,
  output logic [NCORE-1:0] link_out
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= '0;
      link_out <= '0;
    end else begin
      pend     <= (pend | finish) & ~squash & ~grant;
      link_out <= (link_out | link_set) & ~squash & ~grant;
    end
  end
endmodule

// File: rtl/det_commit_seq.sv
module det_commit_seq #(
  parameter int NCORE = 4,
  localparam int IDXW = $clog2(NCORE)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fwd_en,
  input  logic [NCORE-1:0]      quantum_done,
  input  logic [NCORE-1:0]      quantum_ovf,
  input  logic [NCORE-1:0]      conflict,
  input  logic [NCORE-1:0]      fwd_valid,
  input  logic [NCORE*IDXW-1:0] fwd_src,
  output logic [NCORE-1:0]      commit_grant,
  output logic [NCORE-1:0]      squash
);
  logic [IDXW-1:0]  tok;
  logic [NCORE-1:0] pend;
  logic [NCORE-1:0] link_out;
  logic [NCORE-1:0] link_set;
  logic [NCORE-1:0] direct_sq;
  logic [NCORE-1:0] finish;
  logic             tok_advance;

  assign finish      = quantum_done | quantum_ovf;
  assign tok_advance = |commit_grant;

  dcs_token_ring #(.NCORE(NCORE)) u_ring (
    .clk(clk), .rst_n(rst_n), .advance(tok_advance), .tok(tok)
  );

  dcs_squash_net #(.NCORE(NCORE)) u_sq (
    .tok(tok), .fwd_en(fwd_en), .conflict(conflict), .fwd_valid(fwd_valid),
    .fwd_src(fwd_src), .link_out(link_out), .direct_sq(direct_sq),
    .squash(squash), .link_set(link_set)
  );

  dcs_quantum_track #(.NCORE(NCORE)) u_trk (
    .clk(clk), .rst_n(rst_n), .finish(finish), .grant(commit_grant),
    .squash(squash), .link_set(link_set), .pend(pend), .link_out(link_out)
  );

  for (genvar g = 0; g < NCORE; g++) begin : g_grant
    assign commit_grant[g] = (tok == IDXW'(g)) & pend[g] & ~squash[g];
  end
endmodule

// File: rtl/dcs_checker.sv
module dcs_checker #(
  parameter int NCORE = 4,
  localparam int IDXW = $clog2(NCORE)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fwd_en,
  input logic [NCORE-1:0] conflict,
  input logic [NCORE-1:0] fwd_valid,
  input logic [NCORE-1:0] commit_grant,
  input logic [NCORE-1:0] squash
);
  logic [IDXW-1:0] next_owner;

  always_ff @(posedge clk) begin
    if (!rst_n) next_owner <= '0;
    else if (|commit_grant)
      next_owner <= (next_owner == IDXW'(NCORE - 1)) ? '0 : next_owner + 1'b1;
  end

  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(commit_grant));

  p_grant_in_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|commit_grant) |-> (commit_grant == (NCORE'(1) << next_owner)));

  p_squash_beats_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_grant & squash) == '0);

  for (genvar g = 0; g < NCORE; g++) begin : g_core
    p_conflict_squash_r4: assert property (@(posedge clk) disable iff (!rst_n)
      conflict[g] |-> squash[g]);
    p_nofwd_squash_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!fwd_en && fwd_valid[g]) |-> squash[g]);
  end
endmodule

bind det_commit_seq dcs_checker #(.NCORE(NCORE)) u_chk (
  .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en), .conflict(conflict),
  .fwd_valid(fwd_valid), .commit_grant(commit_grant), .squash(squash)
);

// File: tb/sim_det_commit_seq.sv
`timescale 1ns/1ps
module sim_det_commit_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fwd_en = 1'b0;
  logic [3:0] quantum_done = '0;
  logic [3:0] quantum_ovf = '0;
  logic [3:0] conflict = '0;
  logic [3:0] fwd_valid = '0;
  logic [7:0] fwd_src = '0;
  logic [3:0] commit_grant;
  logic [3:0] squash;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  det_commit_seq #(.NCORE(4)) u0 (
    .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en), .quantum_done(quantum_done),
    .quantum_ovf(quantum_ovf), .conflict(conflict), .fwd_valid(fwd_valid),
    .fwd_src(fwd_src), .commit_grant(commit_grant), .squash(squash)
  );

  task automatic do_reset(input logic fe);
    @(negedge clk);
    rst_n = 1'b0; fwd_en = fe;
    quantum_done = '0; quantum_ovf = '0; conflict = '0; fwd_valid = '0; fwd_src = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One clock cycle of stimulus, outputs checked mid-cycle.
  task automatic step(input logic [3:0] d, input logic [3:0] o, input logic [3:0] c,
                      input logic [3:0] fv, input logic [7:0] fs,
                      input logic [3:0] eg, input logic [3:0] es, input string tag);
    @(negedge clk);
    quantum_done = d; quantum_ovf = o; conflict = c; fwd_valid = fv; fwd_src = fs;
    #5;
    checks++;
    if (commit_grant !== eg) begin
      failures++;
      $display("FAIL %s grant got %b expected %b", tag, commit_grant, eg);
    end
    checks++;
    if (squash !== es) begin
      failures++;
      $display("FAIL %s squash got %b expected %b", tag, squash, es);
    end
  endtask

  task automatic t_reset_state;
    do_reset(1'b0);
    step(4'h0, 4'h0, 4'h0, 4'h0, 8'h00, 4'b0000, 4'b0000, "R1 idle after reset");
  endtask

  task automatic t_token_order;
    do_reset(1'b0);
    step(4'b1110, 4'h0, 4'h0, 4'h0, 8'h00, 4'b0000, 4'b0000, "R2 non-holders finish");
    step(4'h0, 4'h0, 4'h0, 4'h0, 8'h00, 4'b0000, 4'b0000, "R5 waiting 1");
    step(4'h0, 4'h0, 4'h0, 4'h0, 8'h00, 4'b0000, 4'b0000, "R5 waiting 2");
    step(4'b0001, 4'h0, 4'h0, 4'h0, 8'h00, 4'b0000, 4'b0000, "R2 holder finishes");
    step(4'h0, 4'h0, 4'h0, 4'h0, 8'h00, 4'b0001, 4'b0000, "R2 grant core0");
    step(4'h0, 4'h0, 4'h0, 4'h0, 8'h00, 4'b0010, 4'b0000, "R3 grant core1");
    step(4'h0, 4'h0, 4'h0, 4'h0, 8'h00, 4'b0100, 4'b0000, "R3 grant core2");
    step(4'h0, 4'h0, 4'h0, 4'h0, 8'h00, 4'b1000, 4'b0000, "R3 grant core3");
    step(4'h0, 4'h0, 4'h0, 4'h0, 8'h00, 4'b0000, 4'b0000, "R3 token waits at core0");
    step(4'b0001, 4'h0, 4'h0, 4'h0, 8'h00, 4'b0000, 4'b0000, "R3 core0 finishes again");
    step(4'h0, 4'h0, 4'h0, 4'h0, 8'h00, 4'b0001, 4'b0000, "R3 wrap grant core0");
  endtask

  task automatic t_conflict;
    do_reset(1'b0);
    step(4'b0001, 4'h0, 4'h0, 4'h0, 8'h00, 4'b0000, 4'b0000, "R4 holder finishes");
    step(4'h0, 4'h0, 4'b0001, 4'h0, 8'h00, 4'b0000, 4'b0001, "R11 squash beats grant");
    step(4'h0, 4'h0, 4'h0, 4'h0, 8'h00, 4'b0000, 4'b0000, "R4 request discarded");
    step(4'h0, 4'h0, 4'b0100, 4'h0, 8'h00, 4'b0000, 4'b0100, "R4 squash core2 only");
    step(4'b0001, 4'h0, 4'h0, 4'h0, 8'h00, 4'b0000, 4'b0000, "R4 core0 refinishes");
    step(4'h0, 4'h0, 4'h0, 4'h0, 8'h00, 4'b0001, 4'b0000, "R11 token did not move");
  endtask

  task automatic t_no_forwarding;
    do_reset(1'b0);
    step(4'h0, 4'h0, 4'h0, 4'b0100, 8'h10, 4'b0000, 4'b0100, "R6 forward rejected");
    step(4'h0, 4'h0, 4'h0, 4'h0, 8'h00, 4'b0000, 4'b0000, "R6 no lingering squash");
  endtask

  task automatic t_forward_rules;
    do_reset(1'b1);
    step(4'h0, 4'h0, 4'h0, 4'b0100, 8'h10, 4'b0000, 4'b0000, "R7 core1 to core2 accepted");
    step(4'h0, 4'h0, 4'h0, 4'h0, 8'h00, 4'b0000, 4'b0000, "R7 no delayed squash");
    do_reset(1'b1);
    step(4'h0, 4'h0, 4'h0, 4'b0010, 8'h0C, 4'b0000, 4'b0010, "R7 later source squashes");
    step(4'h0, 4'h0, 4'h0, 4'b0001, 8'h02, 4'b0000, 4'b0001, "R7 holder cannot consume");
    step(4'h0, 4'h0, 4'h0, 4'b1000, 8'hC0, 4'b0000, 4'b1000, "R7 self forward squashes");
  endtask

  task automatic t_cascade;
    do_reset(1'b1);
    step(4'h0, 4'h0, 4'h0, 4'b0100, 8'h10, 4'b0000, 4'b0000, "R8 link core1 to core2");
    step(4'h0, 4'h0, 4'b0010, 4'h0, 8'h00, 4'b0000, 4'b1110, "R8 cascade from core1");
    step(4'h0, 4'h0, 4'b0010, 4'h0, 8'h00, 4'b0000, 4'b0010, "R9 link cleared by squash");
    do_reset(1'b1);
    step(4'b0001, 4'h0, 4'h0, 4'h0, 8'h00, 4'b0000, 4'b0000, "R8 wrap setup finish");
    step(4'h0, 4'h0, 4'h0, 4'h0, 8'h00, 4'b0001, 4'b0000, "R8 wrap setup grant");
    step(4'h0, 4'h0, 4'h0, 4'b0001, 8'h03, 4'b0000, 4'b0000, "R8 core3 to core0 accepted");
    step(4'h0, 4'h0, 4'b1000, 4'h0, 8'h00, 4'b0000, 4'b1001, "R8 wrapped cascade");
  endtask

  task automatic t_commit_clears_link;
    do_reset(1'b1);
    step(4'b1111, 4'h0, 4'h0, 4'b0010, 8'h00, 4'b0000, 4'b0000, "R9 all finish, core0 feeds core1");
    step(4'h0, 4'h0, 4'h0, 4'h0, 8'h00, 4'b0001, 4'b0000, "R9 source commits");
    step(4'h0, 4'h0, 4'h0, 4'h0, 8'h00, 4'b0010, 4'b0000, "R9 grant core1");
    step(4'h0, 4'h0, 4'h0, 4'h0, 8'h00, 4'b0100, 4'b0000, "R9 grant core2");
    step(4'h0, 4'h0, 4'h0, 4'h0, 8'h00, 4'b1000, 4'b0000, "R9 grant core3");
    step(4'h0, 4'h0, 4'b0001, 4'h0, 8'h00, 4'b0000, 4'b0001, "R9 no cascade after commit");
  endtask

  task automatic t_overflow;
    do_reset(1'b0);
    step(4'h0, 4'b0001, 4'h0, 4'h0, 8'h00, 4'b0000, 4'b0000, "R10 overflow core0");
    step(4'h0, 4'h0, 4'h0, 4'h0, 8'h00, 4'b0001, 4'b0000, "R10 grant after overflow");
    step(4'h0, 4'b0010, 4'h0, 4'h0, 8'h00, 4'b0000, 4'b0000, "R10 overflow core1");
    step(4'h0, 4'h0, 4'h0, 4'h0, 8'h00, 4'b0010, 4'b0000, "R10 grant core1");
    step(4'b0100, 4'b0100, 4'h0, 4'h0, 8'h00, 4'b0000, 4'b0000, "R10 done and overflow");
    step(4'h0, 4'h0, 4'h0, 4'h0, 8'h00, 4'b0100, 4'b0000, "R10 single grant core2");
    step(4'h0, 4'h0, 4'h0, 4'h0, 8'h00, 4'b0000, 4'b0000, "R10 no second request");
  endtask

  task automatic t_collision;
    do_reset(1'b1);
    step(4'b0001, 4'h0, 4'h0, 4'b0100, 8'h10, 4'b0000, 4'b0000, "R8 setup finish and link");
    step(4'h0, 4'h0, 4'b0010, 4'h0, 8'h00, 4'b0001, 4'b1110, "R8 grant with cascade");
    step(4'h0, 4'h0, 4'h0, 4'h0, 8'h00, 4'b0000, 4'b0000, "R4 cascaded requests gone");
  endtask

  initial begin
    t_reset_state();
    t_token_order();
    t_conflict();
    t_no_forwarding();
    t_forward_rules();
    t_cascade();
    t_commit_clears_link();
    t_overflow();
    t_collision();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule